// File: doc/BRIEF.md
# Clock Source Select Control Register

This block holds the byte-wide control and status register that chooses where the system clock comes from. There are three sources: the primary oscillator, a PLL output, and a secondary low-frequency oscillator. Software writes the register through a simple write strobe. The readback shows the stored control bits and the live PLL lock indicator. The block drives a registered two-bit source select and the PLL enable. A glitch-free clock multiplexer elsewhere consumes the select.

Each select bit is gated by its own enabling conditions, and these conditions are re-checked on every clock. A write that asks for a source that is not allowed leaves the bit at zero. A bit that was already set clears on the next edge once its condition goes away. The oscillator mode code decides whether the PLL enable is held high, writable, or held low. The mode code and the switch-block input are static configuration; they may change only while reset is asserted.

Top module: `ccs_clk_src_reg`

## Requirements
- R1: `rd_data[7:4]` always reads 0. `rd_data[3]` is the live `pll_lock` input, and writes to bit 3 have no effect. `rd_data[2]` is the PLL enable, `rd_data[1]` is the PLL select and `rd_data[0]` is the secondary select.
- R2: While `rst_n` is low, the PLL enable, both select bits and `src_sel` are all 0.
- R3: The secondary select bit (write data bit 0) takes the written value only while `sec_switch_block` is 0 and `sec_osc_en` is 1. Otherwise it is 0 after the next clock edge, whatever is written.
- R4: The PLL select bit (write data bit 1) takes the written value only in software-PLL modes, and only while the PLL enable value being established on that edge is 1 and `pll_lock` is 1. Otherwise it is 0 after the next clock edge.
- R5: In hardware-PLL modes (`osc_mode` 0 or 1), the PLL select bit stays 0 even when the PLL is enabled and locked and a 1 is written to it.
- R6: The PLL enable reads 1 one edge after reset in hardware-PLL modes (`osc_mode` 0, 1). In software-PLL modes (`osc_mode` 2, 3) it follows write data bit 2 on each write and holds its value otherwise. In all other modes (`osc_mode` 4 to 7) it stays 0.
- R7: `src_sel` encodes 2'b00 for primary, 2'b01 for PLL and 2'b10 for secondary. When both select bits are 1, `src_sel` is 2'b10. The value 2'b11 never appears.
- R8: A select bit that is set clears on the next edge when its condition drops, with no write needed. Examples are `sec_osc_en` falling or `pll_lock` falling.
- R9: `src_sel` is a register. It changes on the same clock edge that updates the select bits, never between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback |
| osc_mode | input | 3 | Static oscillator mode code |
| sec_switch_block | input | 1 | Static switch block; 1 forbids the secondary source |
| sec_osc_en | input | 1 | Secondary oscillator running |
| pll_lock | input | 1 | PLL lock indicator |
| src_sel | output | 2 | Registered clock source select |
| pll_en | output | 1 | PLL enable |

## Verification
Two functions can fall in the same cycle: a software write to a select bit, and the loss of that bit's enabling condition, either lock or the secondary oscillator dropping. A second such pairing is a write that sets both select bits at once. Random stimulus drives `wr_en`, `pll_lock` and `sec_osc_en` independently every cycle, so these clashes happen often. Directed steps also force them: setting the PLL enable and the PLL select in one write, and writing 1 while the condition is low. The result is judged after the edge against a bench model in which the gate always wins over the write, and the secondary source always wins the encoding.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int REG_W  = 8;
  localparam int MODE_W = 3;
  localparam int SRC_W  = 2;

  localparam int BIT_SEC  = 0;
  localparam int BIT_PSEL = 1;
  localparam int BIT_PEN  = 2;
  localparam int BIT_LOCK = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_PRI = 2'b00,
    SRC_PLL = 2'b01,
    SRC_SEC = 2'b10
  } src_e;

  typedef enum logic [1:0] {
    PLLC_HW   = 2'd0,
    PLLC_SW   = 2'd1,
    PLLC_NONE = 2'd2
  } pll_class_e;

  function automatic pll_class_e mode_class(input logic [MODE_W-1:0] m);
    if (m == 3'd0 || m == 3'd1)      return PLLC_HW;
    else if (m == 3'd2 || m == 3'd3) return PLLC_SW;
    else                             return PLLC_NONE;
  endfunction

  function automatic src_e pick_src(input logic sec, input logic pll);
    if (sec)      return SRC_SEC;
    else if (pll) return SRC_PLL;
    else          return SRC_PRI;
  endfunction
endpackage

// File: rtl/ccs_mode_ctl.sv
module ccs_mode_ctl
  import ccs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] osc_mode,
  input  logic              wr_en,
  input  logic              wr_pen,
  output logic              is_hw,
  output logic              is_sw,
  output logic              pen_d,
  output logic              pen_q
);
  pll_class_e cls;

  always_comb begin
    cls   = mode_class(osc_mode);
    is_hw = (cls == PLLC_HW);
    is_sw = (cls == PLLC_SW);
    unique case (cls)
      PLLC_HW: pen_d = 1'b1;
      PLLC_SW: pen_d = wr_en ? wr_pen : pen_q;
      default: pen_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pen_q <= 1'b0;
    else        pen_q <= pen_d;
  end

  assert_pen_hw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_hw |=> pen_q);
  assert_pen_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_hw && !is_sw) |=> !pen_q);
  assert_pen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sw && !wr_en) |=> $stable(pen_q));
endmodule

// File: rtl/ccs_gated_bit.sv
module ccs_gated_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic wr_en,
  input  logic wr_val,
  output logic bit_d,
  output logic bit_q
);
  always_comb begin
    if (!allow)     bit_d = 1'b0;
    else if (wr_en) bit_d = wr_val;
    else            bit_d = bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end

  // R3 / R4 / R8: a missing condition clears the bit on the next edge
  assert_gate_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> !bit_q);
  assert_gate_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && wr_en) |=> (bit_q == $past(wr_val)));
endmodule

// File: rtl/ccs_src_enc.sv
module ccs_src_enc
  import ccs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_d,
  input  logic             psel_d,
  output logic [SRC_W-1:0] src_q
);
  src_e src_d;

  always_comb src_d = pick_src(sec_d, psel_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= SRC_PRI;
    else        src_q <= src_d;
  end

  assert_no_code3_R7: assert property (@(posedge clk) disable iff (!rst_n)
    src_q != 2'b11);
endmodule

// File: rtl/ccs_clk_src_reg.sv
module ccs_clk_src_reg
  import ccs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic [MODE_W-1:0] osc_mode,
  input  logic              sec_switch_block,
  input  logic              sec_osc_en,
  input  logic              pll_lock,
  output logic [SRC_W-1:0]  src_sel,
  output logic              pll_en
);
  logic is_hw, is_sw, pen_d, pen_q;
  logic sec_allow, psel_allow;
  logic sec_d, sec_q, psel_d, psel_q;

  ccs_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .osc_mode(osc_mode),
    .wr_en(wr_en), .wr_pen(wr_data[BIT_PEN]),
    .is_hw(is_hw), .is_sw(is_sw), .pen_d(pen_d), .pen_q(pen_q)
  );

  assign sec_allow  = !sec_switch_block && sec_osc_en;
  assign psel_allow = is_sw && pen_d && pll_lock;

  ccs_gated_bit u_sec (
    .clk(clk), .rst_n(rst_n), .allow(sec_allow), .wr_en(wr_en),
    .wr_val(wr_data[BIT_SEC]), .bit_d(sec_d), .bit_q(sec_q)
  );

  ccs_gated_bit u_psel (
    .clk(clk), .rst_n(rst_n), .allow(psel_allow), .wr_en(wr_en),
    .wr_val(wr_data[BIT_PSEL]), .bit_d(psel_d), .bit_q(psel_q)
  );

  ccs_src_enc u_enc (
    .clk(clk), .rst_n(rst_n), .sec_d(sec_d), .psel_d(psel_d), .src_q(src_sel)
  );

  always_comb begin
    rd_data           = '0;
    rd_data[BIT_SEC]  = sec_q;
    rd_data[BIT_PSEL] = psel_q;
    rd_data[BIT_PEN]  = pen_q;
    rd_data[BIT_LOCK] = pll_lock;
  end

  assign pll_en = pen_q;

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:4] == 4'h0);
  assert_sec_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q |-> (src_sel == SRC_SEC));
  assert_pll_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_q && psel_q) |-> (src_sel == SRC_PLL));
  assert_hw_no_psel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_hw |=> !psel_q);
endmodule

// File: tb/test_ccs_clk_src_reg.sv
module test_ccs_clk_src_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [2:0] osc_mode = 3'd2;
  logic       sec_switch_block = 1'b0;
  logic       sec_osc_en = 1'b0;
  logic       pll_lock = 1'b0;
  logic [1:0] src_sel;
  logic       pll_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic m_sec, m_psel, m_pen;

  always #4 clk = ~clk;

  ccs_clk_src_reg i_ccs_clk_src_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .osc_mode(osc_mode),
    .sec_switch_block(sec_switch_block), .sec_osc_en(sec_osc_en),
    .pll_lock(pll_lock), .src_sel(src_sel), .pll_en(pll_en)
  );

  function automatic logic exp_pen(input logic [2:0] m, input logic w,
                                   input logic [7:0] d, input logic cur);
    if (m < 3'd2)       return 1'b1;
    else if (m < 3'd4)  return w ? d[2] : cur;
    else                return 1'b0;
  endfunction

  function automatic logic [1:0] exp_src(input logic s, input logic p);
    return s ? 2'b10 : (p ? 2'b01 : 2'b00);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step_model();
    logic pn, sn, qn;
    pn = exp_pen(osc_mode, wr_en, wr_data, m_pen);
    sn = (!sec_switch_block && sec_osc_en) ? (wr_en ? wr_data[0] : m_sec) : 1'b0;
    qn = (osc_mode inside {3'd2, 3'd3} && pn && pll_lock) ? (wr_en ? wr_data[1] : m_psel) : 1'b0;
    @(posedge clk);
    m_pen = pn; m_sec = sn; m_psel = qn;
    @(negedge clk);
  endtask

  task automatic compare_all();
    chk("R1 upper", {4'h0, rd_data[7:4]}, 8'h00);
    chk("R1 lock",  {7'h0, rd_data[3]}, {7'h0, pll_lock});
    chk("R3 sec",   {7'h0, rd_data[0]}, {7'h0, m_sec});
    chk("R4 psel",  {7'h0, rd_data[1]}, {7'h0, m_psel});
    chk("R6 pen",   {6'h0, rd_data[2], pll_en}, {6'h0, m_pen, m_pen});
    chk("R7 src",   {6'h0, src_sel}, {6'h0, exp_src(m_sec, m_psel)});
  endtask

  task automatic do_reset(input logic [2:0] m, input logic blk);
    rst_n = 1'b0; wr_en = 1'b0;
    osc_mode = m; sec_switch_block = blk;
    m_sec = 1'b0; m_psel = 1'b0; m_pen = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 reset rd", rd_data & 8'hF7, 8'h00);
    chk("R2 reset src", {6'h0, src_sel}, 8'h00);
    chk("R2 reset pen", {7'h0, pll_en}, 8'h00);
    rst_n = 1'b1;
  endtask

  task automatic wr_cycle(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step_model();
    wr_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_C10C));
    @(negedge clk);

    // Directed: software-PLL mode, enable and select PLL in one write (R4, R9)
    do_reset(3'd2, 1'b0);
    pll_lock = 1'b1; sec_osc_en = 1'b0;
    step_model();
    wr_cycle(8'h06);
    chk("R9 src after write edge", {6'h0, src_sel}, 8'h01);
    compare_all();
    // both selects with secondary allowed: secondary wins (R7)
    sec_osc_en = 1'b1;
    wr_cycle(8'h07);
    chk("R7 both set", {6'h0, src_sel}, 8'h02);
    // write to lock bit ignored (R1)
    pll_lock = 1'b0;
    wr_cycle(8'hFF);
    chk("R1 lock write ignored", rd_data, 8'h05);
    // secondary condition drops without write (R8)
    sec_osc_en = 1'b0;
    step_model();
    chk("R8 sec drop", {6'h0, rd_data[1:0]}, 8'h00);
    chk("R8 src back to pri", {6'h0, src_sel}, 8'h00);
    // lock drop clears PLL select (R8)
    pll_lock = 1'b1;
    wr_cycle(8'h06);
    pll_lock = 1'b0;
    step_model();
    chk("R8 lock drop", {7'h0, rd_data[1]}, 8'h00);

    // Directed: hardware-PLL mode, PLL select forced clear (R5, R6)
    do_reset(3'd0, 1'b0);
    pll_lock = 1'b1;
    step_model();
    chk("R6 hw pen", {7'h0, pll_en}, 8'h01);
    wr_cycle(8'h02);
    chk("R5 hw psel", {6'h0, src_sel}, 8'h00);
    compare_all();

    // Directed: switch block forbids secondary (R3)
    do_reset(3'd5, 1'b1);
    sec_osc_en = 1'b1;
    wr_cycle(8'h01);
    chk("R3 blocked", {7'h0, rd_data[0]}, 8'h00);

    // Random phases over every mode
    for (int m = 0; m < 8; m++) begin
      do_reset(m[2:0], ($urandom % 4) == 0);
      for (int c = 0; c < 300; c++) begin
        wr_en      = ($urandom % 2) == 0;
        wr_data    = 8'($urandom);
        sec_osc_en = ($urandom % 5) != 0;
        pll_lock   = ($urandom % 5) != 0;
        step_model();
        wr_en = 1'b0;
        compare_all();
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule